// File: doc/BRIEF.md
# DMA Transfer Cycle Timing Sequencer

This block times the individual transfer cycles of one DMA channel in bus clocks. For each transfer it takes a programmed two-bit speed class, a flag saying whether this is the first transfer or a repeated one, and the kind of memory being accessed. The memory can be expansion-bus memory or system memory, and system memory may or may not accept bursts. From these it picks the timing that actually applies to that one cycle. It then drives the I/O read or I/O write command strobe and raises a done pulse in the final bus clock of the cycle.

The faster speed classes are only used when the memory can take them. An access to expansion-bus memory runs at compatible timing for that cycle alone. A burst-class access to system memory that cannot burst runs as a two-clock cycle. Once that happens within a transfer, every later burst-class cycle of the same transfer stays at two clocks. A burst-class cycle to burst-capable memory is paced by the slave's ready input, one data phase per ready clock. Address generation, byte-lane steering, terminal count and channel arbitration belong to neighbouring blocks.

A cycle begins when `start_i` is sampled high at a rising clock edge while the block is idle or in the done clock of the current cycle. Bus clock 1 of the cycle is the clock period that follows that edge. `done_o` is high during the last bus clock L of the cycle.

Top module: `dma_cycle_timer`

## Requirements
- R1: After reset, `eff_mode_o` reads 0, both command strobes and `done_o` are low, and the burst fallback latch is clear, so a repeated burst-class cycle to burst-capable system memory runs as a burst.
- R2: `mode_i` encodes 00 = compatible, 01 = fast class A, 10 = fast class B, 11 = burst. `eff_mode_o` is loaded when a cycle starts and holds until the next start; it reports 0 = compatible, 1 = class A, 2 = class B, 3 = burst, 4 = two-clock non-burst.
- R3: A compatible cycle lasts 9 bus clocks when `rep_i` is 0 and 8 bus clocks when `rep_i` is 1.
- R4: A class A cycle to system memory lasts 7 bus clocks for a first transfer and 6 for a repeated one.
- R5: A class B cycle to system memory lasts 6 bus clocks for a first transfer and 4 for a repeated one.
- R6: When `mem_isa_i` is 1, a cycle in class A, class B or burst runs with compatible timing and length. The following cycle is judged afresh from its own inputs.
- R7: A burst cycle to burst-capable system memory (`mem_burst_i` = 1) raises `done_o` in the first of its bus clocks in which `rdy_i` is high. While `rdy_i` is low it waits. A start held high gives one completed cycle per bus clock.
- R8: A burst-class cycle to system memory with `mem_burst_i` = 0 lasts exactly 2 bus clocks whatever `rdy_i` does, and it sets the fallback latch.
- R9: While the fallback latch is set, every burst-class repeated cycle to system memory is a two-clock cycle, even when `mem_burst_i` is 1. A compatible cycle caused by expansion-bus memory leaves the latch unchanged.
- R10: A start with `rep_i` = 0 clears the fallback latch before the cycle's timing is chosen, whatever the mode.
- R11: Command strobe timing: in a cycle of length L ≥ 4, the strobe is active in bus clocks 2 to L−1. In a two-clock cycle it is active in bus clock 1 only. In a burst cycle it is active in every bus clock of the cycle.
- R12: `dir_i` is sampled at start. 1 selects `io_wr_o` and 0 selects `io_rd_o`. The two strobes are never high together.
- R13: A start sampled during a cycle, other than in its done clock, is ignored: the running cycle keeps its length and effective mode, and no further cycle follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Programmed speed class |
| start_i | input | 1 | Begin a transfer cycle |
| rep_i | input | 1 | 1 = repeated transfer of a block/demand run, 0 = first transfer |
| mem_isa_i | input | 1 | Target memory sits on the expansion bus |
| mem_burst_i | input | 1 | Target system memory accepts bursts |
| dir_i | input | 1 | 1 = memory to I/O (I/O write), 0 = I/O read |
| rdy_i | input | 1 | Slave ready, paces burst cycles |
| io_rd_o | output | 1 | I/O read command strobe, active high |
| io_wr_o | output | 1 | I/O write command strobe, active high |
| done_o | output | 1 | High in the last bus clock of a cycle |
| eff_mode_o | output | 3 | Timing actually used for the current cycle |

## Verification
Every speed class is driven through both first and repeated transfers to system memory, so that each of the six fixed lengths is told apart from its neighbours. The same classes are then driven against expansion-bus memory and followed at once by a system-memory cycle, which separates a per-cycle fallback from a sticky one. Burst runs mix burst-capable and non-burst memory, ready wait states and an expansion-bus cycle in the middle. This shows whether the fallback latch sets, holds across page changes and interruptions, and clears only on a new transfer. Start pulses held through the done clock, and start pulses given mid-cycle, separate back-to-back acceptance from a start that must be ignored.

// File: rtl/dma_tmg_pkg.sv
package dma_tmg_pkg;

  localparam int LEN_W = 4;

  typedef enum logic [1:0] {
    MODE_COMPAT = 2'b00,
    MODE_FASTA  = 2'b01,
    MODE_FASTB  = 2'b10,
    MODE_BURST  = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    EFF_COMPAT = 3'd0,
    EFF_FASTA  = 3'd1,
    EFF_FASTB  = 3'd2,
    EFF_BURST  = 3'd3,
    EFF_TWOCLK = 3'd4
  } eff_e;

  // Fixed cycle length in bus clocks; burst cycles are open-ended (0).
  function automatic logic [LEN_W-1:0] eff_len(eff_e eff, logic rep);
    logic [LEN_W-1:0] n;
    case (eff)
      EFF_COMPAT: n = rep ? LEN_W'(8) : LEN_W'(9);
      EFF_FASTA:  n = rep ? LEN_W'(6) : LEN_W'(7);
      EFF_FASTB:  n = rep ? LEN_W'(4) : LEN_W'(6);
      EFF_TWOCLK: n = LEN_W'(2);
      default:    n = '0;
    endcase
    return n;
  endfunction

  // Choose the timing for one cycle from class, memory type and fallback.
  function automatic eff_e pick_eff(mode_e mode, logic isa, logic bcap, logic fb);
    eff_e e;
    case (mode)
      MODE_FASTA: e = isa ? EFF_COMPAT : EFF_FASTA;
      MODE_FASTB: e = isa ? EFF_COMPAT : EFF_FASTB;
      MODE_BURST: e = isa ? EFF_COMPAT : ((bcap && !fb) ? EFF_BURST : EFF_TWOCLK);
      default:    e = EFF_COMPAT;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/dma_tmg_select.sv
module dma_tmg_select
  import dma_tmg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       rep_i,
  input  logic       mem_isa_i,
  input  logic       mem_burst_i,
  input  logic       accept_i,
  output eff_e       eff_sel_o,
  output eff_e       eff_q_o,
  output logic       fb_o
);

  logic fb_q;
  logic fb_base;
  logic fb_set;
  eff_e eff_sel;
  eff_e eff_q;

  // A first transfer starts with a clean fallback state.
  assign fb_base = rep_i ? fb_q : 1'b0;
  assign eff_sel = pick_eff(mode_e'(mode_i), mem_isa_i, mem_burst_i, fb_base);
  assign fb_set  = (eff_sel == EFF_TWOCLK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fb_q  <= 1'b0;
      eff_q <= EFF_COMPAT;
    end else if (accept_i) begin
      fb_q  <= fb_base | fb_set;
      eff_q <= eff_sel;
    end
  end

  assign eff_sel_o = eff_sel;
  assign eff_q_o   = eff_q;
  assign fb_o      = fb_q;

endmodule

// File: rtl/dma_tmg_counter.sv
module dma_tmg_counter
  import dma_tmg_pkg::*;
#(
  parameter int CNT_W = LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             rep_i,
  input  logic             dir_i,
  input  logic             rdy_i,
  input  eff_e             eff_sel_i,
  output logic             accept_o,
  output logic             done_o,
  output logic             busy_o,
  output logic             burst_o,
  output logic             dir_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] len_o
);

  logic             busy_q;
  logic             burst_q;
  logic             dir_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic             done;
  logic             accept;

  assign done   = busy_q && (burst_q ? rdy_i : (cnt_q == len_q));
  assign accept = start_i && (!busy_q || done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      burst_q <= 1'b0;
      dir_q   <= 1'b0;
      cnt_q   <= '0;
      len_q   <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      burst_q <= (eff_sel_i == EFF_BURST);
      dir_q   <= dir_i;
      cnt_q   <= CNT_W'(1);
      len_q   <= CNT_W'(eff_len(eff_sel_i, rep_i));
    end else if (done) begin
      busy_q  <= 1'b0;
    end else if (busy_q && !burst_q) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign accept_o = accept;
  assign done_o   = done;
  assign busy_o   = busy_q;
  assign burst_o  = burst_q;
  assign dir_o    = dir_q;
  assign cnt_o    = cnt_q;
  assign len_o    = len_q;

endmodule

// File: rtl/dma_tmg_strobe.sv
module dma_tmg_strobe #(
  parameter int CNT_W = 4
) (
  input  logic             busy_i,
  input  logic             burst_i,
  input  logic             dir_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             io_rd_o,
  output logic             io_wr_o
);

  logic two_clk;
  logic in_window;
  logic active;

  assign two_clk   = (len_i == CNT_W'(2));
  assign in_window = ((cnt_i >= CNT_W'(2)) || two_clk) && (cnt_i < len_i);
  assign active    = busy_i && (burst_i || in_window);

  assign io_rd_o = active && !dir_i;
  assign io_wr_o = active && dir_i;

endmodule

// File: rtl/dma_cycle_timer.sv
module dma_cycle_timer
  import dma_tmg_pkg::*;
#(
  parameter int CNT_W = LEN_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       start_i,
  input  logic       rep_i,
  input  logic       mem_isa_i,
  input  logic       mem_burst_i,
  input  logic       dir_i,
  input  logic       rdy_i,
  output logic       io_rd_o,
  output logic       io_wr_o,
  output logic       done_o,
  output logic [2:0] eff_mode_o
);

  eff_e             eff_sel_w;
  eff_e             eff_q_w;
  logic             fb_w;
  logic             accept_w;
  logic             busy_w;
  logic             burst_w;
  logic             dir_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] len_w;

  dma_tmg_select i_select (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .rep_i       (rep_i),
    .mem_isa_i   (mem_isa_i),
    .mem_burst_i (mem_burst_i),
    .accept_i    (accept_w),
    .eff_sel_o   (eff_sel_w),
    .eff_q_o     (eff_q_w),
    .fb_o        (fb_w)
  );

  dma_tmg_counter #(.CNT_W(CNT_W)) i_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rep_i     (rep_i),
    .dir_i     (dir_i),
    .rdy_i     (rdy_i),
    .eff_sel_i (eff_sel_w),
    .accept_o  (accept_w),
    .done_o    (done_o),
    .busy_o    (busy_w),
    .burst_o   (burst_w),
    .dir_o     (dir_w),
    .cnt_o     (cnt_w),
    .len_o     (len_w)
  );

  dma_tmg_strobe #(.CNT_W(CNT_W)) i_strobe (
    .busy_i  (busy_w),
    .burst_i (burst_w),
    .dir_i   (dir_w),
    .cnt_i   (cnt_w),
    .len_i   (len_w),
    .io_rd_o (io_rd_o),
    .io_wr_o (io_wr_o)
  );

  assign eff_mode_o = eff_q_w;

endmodule

// File: rtl/dma_cycle_timer_chk.sv
module dma_cycle_timer_chk
  import dma_tmg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       rep_i,
  input logic       mem_isa_i,
  input logic       mem_burst_i,
  input logic       io_rd_o,
  input logic       io_wr_o,
  input logic       done_o,
  input logic [2:0] eff_mode_o,
  input logic       accept_w,
  input logic       busy_w,
  input logic       fb_w
);

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd_o && io_wr_o));

  // R13
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_w);

  // R2
  eff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_w |=> $stable(eff_mode_o));

  // R6
  isa_compat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && mode_i != 2'b00 && mem_isa_i) |=> (eff_mode_o == 3'd0));

  // R8
  nonburst_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && mode_i == 2'b11 && !mem_isa_i && !mem_burst_i)
      |=> (eff_mode_o == 3'd4 && fb_w));

  // R9
  fb_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && rep_i && fb_w) |=> fb_w);

  // R9
  fb_no_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && rep_i && fb_w && mode_i == 2'b11 && !mem_isa_i)
      |=> (eff_mode_o == 3'd4));

  // R10
  fb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && !rep_i && mode_i != 2'b11) |=> !fb_w);

  // R11
  burst_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && eff_mode_o == 3'd3) |-> (io_rd_o || io_wr_o));

  // R11
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && eff_mode_o != 3'd3 && eff_mode_o != 3'd4) |-> !(io_rd_o || io_wr_o));

endmodule

bind dma_cycle_timer dma_cycle_timer_chk i_chk (.*);

// File: tb/test_dma_cycle_timer.sv
module test_dma_cycle_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       start = 1'b0;
  logic       rep = 1'b0;
  logic       isa = 1'b0;
  logic       bcap = 1'b0;
  logic       dir = 1'b0;
  logic       rdy = 1'b1;
  logic       io_rd;
  logic       io_wr;
  logic       done;
  logic [2:0] eff;

  always #4 clk = ~clk;

  dma_cycle_timer i_dma_cycle_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode),
    .start_i     (start),
    .rep_i       (rep),
    .mem_isa_i   (isa),
    .mem_burst_i (bcap),
    .dir_i       (dir),
    .rdy_i       (rdy),
    .io_rd_o     (io_rd),
    .io_wr_o     (io_wr),
    .done_o      (done),
    .eff_mode_o  (eff)
  );

  typedef struct {
    logic [2:0] eff;
    int         len;
    logic       dir;
    logic       burst;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  exp_t cur;
  int   n_run = 0;
  int   n_fail = 0;
  int   k = 0;
  bit   in_cyc = 1'b0;
  bit   strb_bad = 1'b0;
  bit   exp_act;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: follows the cycle at the head of the queue, one sample per bus clock.
  always @(negedge clk) begin
    if (in_cyc) begin
      k = k + 1;
      cur = sb_q[0];
      exp_act = cur.burst || (((k >= 2) || (cur.len == 2)) && (k < cur.len));
      if (exp_act) begin
        if (io_wr !== cur.dir || io_rd !== !cur.dir) strb_bad = 1'b1;
      end else if (io_rd || io_wr) begin
        strb_bad = 1'b1;
      end
      if (done) begin
        chk(k == cur.len, cur.tag, "cycle length", k, cur.len);
        chk(eff == cur.eff, cur.tag, "effective mode R2", int'(eff), int'(cur.eff));
        chk(!strb_bad, cur.tag, "strobe window R11 R12", int'(strb_bad), 0);
        void'(sb_q.pop_front());
        in_cyc = 1'b0;
      end
    end
  end

  // Driver: one cycle with given inputs; w = ready wait clocks.
  task automatic run(input logic [1:0] m, input logic rp, input logic is,
                     input logic bc, input logic dr, input int w,
                     input logic [2:0] ee, input int el, input string tag);
    @(negedge clk);
    mode = m; rep = rp; isa = is; bcap = bc; dir = dr;
    rdy = (w == 0);
    start = 1'b1;
    sb_q.push_back('{ee, el, dr, (ee == 3'd3), tag});
    @(posedge clk);
    k = 0; strb_bad = 1'b0; in_cyc = 1'b1;
    #1 start = 1'b0;
    if (w > 0) begin
      repeat (w) @(posedge clk);
      #1 rdy = 1'b1;
    end
    wait (!in_cyc);
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!io_rd && !io_wr, "R1", "strobes in reset", int'(io_rd | io_wr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done, "R1", "done after reset", int'(done), 0);
    chk(eff == 3'd0, "R1", "eff after reset", int'(eff), 0);
    chk(!io_rd && !io_wr, "R1", "strobes after reset", int'(io_rd | io_wr), 0);

    // Latch starts clear: repeated burst to burst memory bursts.
    run(2'b11, 1, 0, 1, 0, 0, 3'd3, 1, "R1");
    run(2'b00, 0, 0, 0, 0, 0, 3'd0, 9, "R3");
    run(2'b00, 1, 0, 0, 1, 0, 3'd0, 8, "R3");
    run(2'b01, 0, 0, 0, 0, 0, 3'd1, 7, "R4");
    run(2'b01, 1, 0, 0, 1, 0, 3'd1, 6, "R4");
    run(2'b10, 0, 0, 0, 1, 0, 3'd2, 6, "R5");
    run(2'b10, 1, 0, 0, 0, 0, 3'd2, 4, "R5");
    run(2'b01, 0, 1, 0, 0, 0, 3'd0, 9, "R6");
    run(2'b01, 1, 0, 0, 0, 0, 3'd1, 6, "R6");
    run(2'b10, 1, 1, 0, 1, 0, 3'd0, 8, "R6");
    run(2'b10, 1, 0, 0, 1, 0, 3'd2, 4, "R6");
    run(2'b11, 0, 0, 1, 0, 0, 3'd3, 1, "R7");
    run(2'b11, 1, 0, 1, 1, 2, 3'd3, 3, "R7");
    run(2'b11, 1, 0, 0, 0, 0, 3'd4, 2, "R8");
    run(2'b11, 1, 0, 1, 0, 0, 3'd4, 2, "R9");
    run(2'b11, 1, 1, 1, 1, 0, 3'd0, 8, "R9");
    run(2'b11, 1, 0, 1, 1, 3, 3'd4, 2, "R9");
    run(2'b11, 0, 0, 1, 0, 0, 3'd3, 1, "R10");
    run(2'b11, 1, 0, 0, 0, 0, 3'd4, 2, "R8");
    run(2'b00, 0, 0, 0, 0, 0, 3'd0, 9, "R10");
    run(2'b11, 1, 0, 1, 0, 0, 3'd3, 1, "R10");

    // R7: start held through done clocks gives one cycle per clock.
    @(negedge clk);
    mode = 2'b11; rep = 1'b0; isa = 1'b0; bcap = 1'b1; dir = 1'b1; rdy = 1'b1;
    start = 1'b1;
    @(posedge clk); #1 rep = 1'b1;
    @(negedge clk);
    chk(done && io_wr, "R7", "back-to-back clock 1", int'(done), 1);
    @(posedge clk);
    @(negedge clk);
    chk(done && io_wr, "R7", "back-to-back clock 2", int'(done), 1);
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    chk(done && io_wr, "R7", "back-to-back clock 3", int'(done), 1);
    @(negedge clk);
    chk(!done && !io_wr, "R7", "idle after run", int'(done), 0);

    // R13: start given mid-cycle with another class is ignored.
    @(negedge clk);
    mode = 2'b00; rep = 1'b0; isa = 1'b0; bcap = 1'b0; dir = 1'b0; rdy = 1'b1;
    start = 1'b1;
    sb_q.push_back('{3'd0, 9, 1'b0, 1'b0, "R13"});
    @(posedge clk);
    k = 0; strb_bad = 1'b0; in_cyc = 1'b1;
    #1 start = 1'b0;
    @(posedge clk); #1 mode = 2'b10; rep = 1'b1; start = 1'b1;
    @(posedge clk); #1 start = 1'b0; mode = 2'b00;
    wait (!in_cyc);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!done && !io_rd && !io_wr, "R13", "no cycle after ignored start",
          int'(done | io_rd), 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule